// File: doc/BRIEF.md
# Virtual Running Priority Tracker

This block follows the running priority of a virtual CPU interrupt interface. Each acknowledge event places an interrupt on a stack of active interrupts. The event carries an 8-bit priority and a non-maskable flag. Each priority-drop event takes away the most recent active interrupt whose priority has not yet dropped. From the entries that remain, the block forms a 64-bit status word. The word holds the group priority of the most urgent entry and a flag that is set while a non-maskable interrupt is among those entries.

A lower numeric priority is more urgent. The group priority is the priority with every unimplemented low bit cleared. When all 8 priority bits are implemented, bit 0 is also cleared, as if the binary point stood at its minimum. When no entry is held, the priority field shows the idle value. The idle value is all ones in the implemented bits and zero below them. The parameters set the number of implemented priority bits (`PRI_BITS`), the stack depth (`DEPTH`) and whether the non-maskable flag is supported (`NMI_EN`).

A small state machine governs the stack. It has three states:
- `ST_EMPTY`: no entry is held.
- `ST_HOLD`: some entries are held, but the stack is not full.
- `ST_FULL`: `DEPTH` entries are held.

The transitions are named as follows:
- push: `ST_EMPTY`->`ST_HOLD`, `ST_HOLD`->`ST_FULL`, or `ST_EMPTY`->`ST_FULL` when `DEPTH` is 1.
- pop: `ST_FULL`->`ST_HOLD`, `ST_HOLD`->`ST_EMPTY`, or `ST_FULL`->`ST_EMPTY` when `DEPTH` is 1.
- swap: acknowledge and drop in the same cycle while entries are held. The state does not change.

Every other combination leaves the state where it is.

Top module: `rpr_tracker`

## Requirements
- R1: A synchronous active-low reset empties the stack. After reset, bits [7:0] read the idle value (0xFF when `PRI_BITS`=8, 0xF8 when `PRI_BITS`=5) and bit 63 reads 0.
- R2: Bits [62:8] of `rpr_word` always read 0.
- R3: When no active, undropped entry remains, bits [7:0] read the idle value.
- R4: Bits [7:0] hold the numerically smallest group priority among the held entries.
- R5: The group priority is the priority with its `8-PRI_BITS` low bits cleared. When `PRI_BITS`=8, bit 0 is also cleared.
- R6: With `NMI_EN`=1, bit 63 is 1 exactly when a held entry was acknowledged with `ack_nmi`=1.
- R7: With `NMI_EN`=0, bit 63 always reads 0.
- R8: `drop_valid` removes the most recently acknowledged entry that is still held (last in, first out). The word reflects this one cycle after the edge.
- R9: An acknowledge while `DEPTH` entries are held, with no drop in that cycle, is ignored. A drop while the stack is empty is ignored.
- R10: When acknowledge and drop occur in the same cycle, the drop is applied to the entries held before that cycle, and then the new entry is pushed. So when the stack is full, the top entry is replaced. When the stack is empty, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_valid | input | 1 | Acknowledge event this cycle |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_nmi | input | 1 | Acknowledged interrupt is non-maskable |
| drop_valid | input | 1 | Priority-drop event this cycle |
| rpr_word | output | 64 | Running-priority word: bit 63 NMI flag, [7:0] group priority |

## Verification
Acknowledge and priority drop can occur in the same cycle, and their ordering decides what the stack holds afterwards. The bench provokes this in directed steps on a full stack, where the top entry must be replaced, and on an empty stack, where only the push may take effect. Random stimulus also raises both events together often. A bench model applies the drop before the push, and every resulting word is compared against that model for three parameter sets at once.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

    localparam int PRIO_W = 8;

    typedef struct packed {
        logic              nmi;
        logic [PRIO_W-1:0] prio;
    } rpr_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FULL  = 2'd2
    } rpr_state_e;

    // bits that exist for a given implemented width
    function automatic logic [PRIO_W-1:0] impl_mask(input int pri_bits);
        return 8'hFF << (PRIO_W - pri_bits);
    endfunction

    // group priority at minimum binary point
    function automatic logic [PRIO_W-1:0] group_mask(input int pri_bits);
        logic [PRIO_W-1:0] m;
        m = impl_mask(pri_bits);
        if (pri_bits == PRIO_W) m[0] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/rpr_stack.sv
module rpr_stack
    import rpr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  logic       drop_req,
    input  rpr_entry_t push_data,
    output rpr_entry_t ent_o [DEPTH],
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rpr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, wr_idx;
    logic             push_ok, pop_ok;
    rpr_entry_t       ent_q [DEPTH];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // per-state actions and next state
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                push_ok = push_req;
            end
            ST_HOLD: begin
                push_ok = push_req;
                pop_ok  = drop_req;
            end
            ST_FULL: begin
                pop_ok  = drop_req;
                push_ok = push_req && drop_req;
            end
            default: begin
                push_ok = 1'b0;
                pop_ok  = 1'b0;
            end
        endcase

        cnt_d = cnt_q;
        if (pop_ok && !push_ok)      cnt_d = cnt_q - 1'b1;
        else if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
        wr_idx = pop_ok ? cnt_q - 1'b1 : cnt_q;

        if (cnt_d == '0)           state_d = ST_EMPTY;
        else if (cnt_d == FULL_CNT) state_d = ST_FULL;
        else                        state_d = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) begin
                if (push_ok && int'(wr_idx) == i) ent_q[i] <= push_data;
            end
        end
    end

    assign ent_o = ent_q;
    assign cnt_o = cnt_q;

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    a_r9_full_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && push_req && !drop_req) |=> (cnt_q == FULL_CNT));
    a_r8_drop_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_req && !push_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_req && push_req && cnt_q != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/rpr_format.sv
module rpr_format
    import rpr_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int CNT_W    = 3,
    parameter int PRI_BITS = 8,
    parameter bit NMI_EN   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rpr_entry_t       ent_i [DEPTH],
    input  logic [CNT_W-1:0] cnt_i,
    output logic [63:0]      rpr_word
);

    localparam logic [PRIO_W-1:0] GMASK = group_mask(PRI_BITS);
    localparam logic [PRIO_W-1:0] IDLE  = impl_mask(PRI_BITS);

    logic [PRIO_W-1:0] best, grp;
    logic              nmi_any;

    always_comb begin
        best    = IDLE;
        nmi_any = 1'b0;
        grp     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt_i)) begin
                grp = ent_i[i].prio & GMASK;
                if (grp < best) best = grp;
                nmi_any = nmi_any | ent_i[i].nmi;
            end
        end
        rpr_word = {nmi_any & NMI_EN, 55'd0, best};
    end

    a_r3_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |-> (rpr_word[7:0] == IDLE && !rpr_word[63]));
    a_r5_field_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> ((rpr_word[7:0] & ~GMASK) == '0));
    a_r6_nmi_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_word[63] |-> (cnt_i != '0));

endmodule

// File: rtl/rpr_tracker.sv
module rpr_tracker
    import rpr_pkg::*;
#(
    parameter int PRI_BITS = 8,
    parameter int DEPTH    = 4,
    parameter bit NMI_EN   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack_valid,
    input  logic [7:0]  ack_prio,
    input  logic        ack_nmi,
    input  logic        drop_valid,
    output logic [63:0] rpr_word
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    rpr_entry_t       ent [DEPTH];
    rpr_entry_t       push_data;
    logic [CNT_W-1:0] cnt;

    assign push_data = '{nmi: ack_nmi, prio: ack_prio};

    rpr_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (ack_valid),
        .drop_req  (drop_valid),
        .push_data (push_data),
        .ent_o     (ent),
        .cnt_o     (cnt)
    );

    rpr_format #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PRI_BITS(PRI_BITS), .NMI_EN(NMI_EN)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_i    (ent),
        .cnt_i    (cnt),
        .rpr_word (rpr_word)
    );

endmodule

// File: tb/tb_rpr_tracker.sv
module tb_rpr_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_prio = '0;
    logic        ack_nmi = 1'b0;
    logic        drop_valid = 1'b0;
    logic [63:0] w8, w5, wn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int         m_cnt = 0;
    logic [7:0] m_prio [DEPTH];
    logic       m_nmi  [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    rpr_tracker #(.PRI_BITS(8), .DEPTH(DEPTH), .NMI_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
        .ack_nmi(ack_nmi), .drop_valid(drop_valid), .rpr_word(w8));
    rpr_tracker #(.PRI_BITS(5), .DEPTH(DEPTH), .NMI_EN(1'b0)) dut_p5 (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
        .ack_nmi(ack_nmi), .drop_valid(drop_valid), .rpr_word(w5));
    rpr_tracker #(.PRI_BITS(8), .DEPTH(DEPTH), .NMI_EN(1'b0)) dut_nn (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_prio(ack_prio),
        .ack_nmi(ack_nmi), .drop_valid(drop_valid), .rpr_word(wn));

    function automatic logic [63:0] exp_word(int pbits, bit nmi_en);
        logic [7:0] imask, gmask, best;
        logic       n;
        imask = 8'hFF << (8 - pbits);
        gmask = (pbits == 8) ? 8'hFE : imask;
        best  = imask;
        n     = 1'b0;
        for (int i = 0; i < m_cnt; i++) begin
            if ((m_prio[i] & gmask) < best) best = m_prio[i] & gmask;
            n = n | m_nmi[i];
        end
        return {n & nmi_en, 55'd0, best};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " pri8"}, w8, exp_word(8, 1'b1));
        check({tag, " pri5"}, w5, exp_word(5, 1'b0));
        check({tag, " no-nmi"}, wn, exp_word(8, 1'b0));
    endtask

    // drive at negedge, model at posedge (drop first, then push), check at next negedge
    task automatic step(bit a, logic [7:0] p, bit n, bit d, string tag);
        ack_valid = a; ack_prio = p; ack_nmi = n; drop_valid = d;
        @(posedge clk);
        if (d && m_cnt > 0) m_cnt--;
        if (a && m_cnt < DEPTH) begin
            m_prio[m_cnt] = p;
            m_nmi[m_cnt]  = n;
            m_cnt++;
        end
        @(negedge clk);
        ack_valid = 1'b0; drop_valid = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset idle");
        check("R1 idle value 0xFF", {56'd0, w8[7:0]}, 64'hFF);
        check("R1 idle value 0xF8", {56'd0, w5[7:0]}, 64'hF8);

        step(1, 8'h80, 0, 0, "R4 single entry");
        step(1, 8'h41, 0, 0, "R5 bit0 cleared");
        check("R5 low bit", {56'd0, w8[7:0]}, 64'h40);
        step(1, 8'h47, 0, 0, "R4 smaller wins");
        step(1, 8'h13, 1, 0, "R6 nmi entry");
        check("R6 nmi set", {63'd0, w8[63]}, 64'd1);
        check("R7 nmi off", {63'd0, w5[63] | wn[63]}, 64'd0);
        step(1, 8'h00, 0, 0, "R9 full ack ignored");
        check("R9 still 0x12", {56'd0, w8[7:0]}, 64'h12);
        step(1, 8'h05, 0, 1, "R10 swap on full");
        check("R10 replaced top", w8, 64'h04);
        step(0, 8'h00, 0, 1, "R8 lifo drop");
        check("R8 after drop", w8, 64'h40);
        step(0, 8'h00, 0, 1, "R8 drop");
        step(0, 8'h00, 0, 1, "R8 drop");
        step(0, 8'h00, 0, 1, "R3 all dropped");
        check("R3 idle 8", w8, 64'hFF);
        check("R3 idle 5", w5, 64'hF8);
        step(0, 8'h00, 0, 1, "R9 drop on empty");
        step(1, 8'hC3, 1, 1, "R10 both on empty");
        check("R10 push only", w8, {1'b1, 55'd0, 8'hC2});
        step(0, 8'h00, 0, 1, "R3 back idle");

        for (int k = 0; k < 400; k++) begin
            step($urandom_range(0, 99) < 55, 8'($urandom), 1'($urandom),
                 $urandom_range(0, 99) < 40, "R4 random");
            check("R2 reserved zero", {8'd0, w8[62:8], 1'b0}, 64'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule